// File: doc/BRIEF.md
# Address-Range Port Protection Checker

This block holds a table of access rules in front of a memory controller. Every cycle it receives a transaction: an address, a requesting port number, a transaction ID and a secure/non-secure flag. One cycle later it returns a verdict, accept or reject. A rule covers a window of 1 MB pages, an inclusive range of transaction IDs, a set of ports and the security attributes it admits. When several rules cover a transaction, the rule with the lowest number decides. When no rule covers it, a per-port default mask decides.

Software reaches the rules indirectly. Three staging words are written first: the page window, the ID range, and the attributes. A write to the command register then names a rule and either commits the staged words into that rule or loads that rule back into the staging words so it can be read. The same small register port also holds the default mask. The table can be rewritten while traffic flows. A request arrives in the same cycle as a commit is still judged against the table as it was before that commit.

Top module: `prot_checker`

## Requirements
- R1: After reset every rule is invalid and every register reads zero, including the staging words, the command register and the default mask. Every valid request is then accepted.
- R2: The command register is at select 0. Bits [4:0] hold a rule number, and it reads back only that number; bits 5 and 6 always read 0. Writing it with bit 5 set copies the three staging words into the named rule.
- R3: Writing the command register with bit 6 set and bit 5 clear copies the named rule into the staging words. With both bits set, only the commit happens. A rule number of 20 or more makes both commands do nothing, although the number is still stored.
- R4: The staging words and their layout are as follows. The window word (select 1) holds the low page in [11:0] and the high page in [23:12], where a page is address bits [31:20]. The ID word (select 2) holds the low ID in [11:0] and the high ID in [23:12]. The attribute word (select 3) holds security in [1:0] (bit 0 admits non-secure, bit 1 admits secure), valid in bit 2, the port mask in [12:3] (bit 3+p stands for port p) and the result in bit 13 (0 accept, 1 reject). Unused bits read 0.
- R5: A rule matches when all of these hold: it is valid; the page lies between its low and high bounds inclusive; the ID lies between its low and high bounds inclusive; its mask bit for the port is set; and its security bit for the request's attribute is set.
- R6: When several rules match, the lowest-numbered matching rule gives the result.
- R7: When no rule matches, the default mask (select 4, bits [9:0]) decides: a 1 in bit p rejects port p and a 0 accepts it.
- R8: A request whose port number is 10 or more is always rejected.
- R9: The response valid equals the request valid of the previous cycle. While it is high, exactly one of accept and reject is high; while it is low, both are low.
- R10: A request presented in the same cycle as a commit is judged with the rule as it was before the commit. A request in the following cycle sees the new rule.
- R11: The default register stores and reads back 10 bits. Writes to selects 5 to 7 are ignored, and those selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| req_valid_i | input | 1 | Transaction present |
| req_addr_i | input | 32 | Transaction address |
| req_port_i | input | 4 | Requesting port number |
| req_id_i | input | 12 | Transaction ID |
| req_secure_i | input | 1 | 1 for secure, 0 for non-secure |
| rsp_valid_o | output | 1 | Verdict present |
| rsp_accept_o | output | 1 | Transaction accepted |
| rsp_reject_o | output | 1 | Transaction rejected |

## Verification
The hardest cases to reach are a request that lands exactly on a bound shared by two overlapping rules with different results, and a commit in the same cycle as a request to the window being changed. The stimulus builds a low-numbered accepting rule that sits inside a higher-numbered rejecting rule. It then walks each bound of the page, ID, port and security conditions one at a time. It also issues a commit and a request in one cycle and repeats the request in the next cycle. A long run of mixed register writes, loads and requests follows, with pages and IDs kept in a narrow range so that overlaps happen often. A behavioural model checks every cycle of that run.

// File: rtl/prot_chk_pkg.sv
`timescale 1ns/1ps
package prot_chk_pkg;
  parameter int unsigned N_RULES = 20;
  parameter int unsigned N_PORTS = 10;
  parameter int unsigned ADDR_W  = 32;
  parameter int unsigned PAGE_W  = 12;
  parameter int unsigned ID_W    = 12;
  parameter int unsigned SEC_W   = 2;
  parameter int unsigned DATA_W  = 32;
  localparam int unsigned RSEL_W = $clog2(N_RULES);
  localparam int unsigned PORT_W = $clog2(N_PORTS);
  localparam int unsigned ATTR_W = SEC_W + 2 + N_PORTS;

  typedef struct packed {
    logic [PAGE_W-1:0]  hi_pg;
    logic [PAGE_W-1:0]  lo_pg;
    logic [ID_W-1:0]    hi_id;
    logic [ID_W-1:0]    lo_id;
    logic               result;
    logic [N_PORTS-1:0] pmask;
    logic               valid;
    logic [SEC_W-1:0]   sec;
  } rule_t;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_WIN  = 3'd1,
    SEL_IDR  = 3'd2,
    SEL_ATTR = 3'd3,
    SEL_DFLT = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/prot_rule_regs.sv
`timescale 1ns/1ps
module prot_rule_regs
  import prot_chk_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [2:0]                cfg_sel_i,
  input  logic [DATA_W-1:0]         cfg_wdata_i,
  output logic [DATA_W-1:0]         cfg_rdata_o,
  output rule_t [N_RULES-1:0]       rules_o,
  output logic [N_PORTS-1:0]        dflt_o
);
  localparam logic [RSEL_W-1:0] LAST_RULE = RSEL_W'(N_RULES - 1);

  rule_t              stage_q;
  rule_t              load_rule;
  logic [RSEL_W-1:0]  sel_q;
  logic [N_PORTS-1:0] dflt_q;
  logic [RSEL_W-1:0]  rnum;
  logic               cmd_wr, in_rng, do_commit, do_load;
  logic               unused_wdata;

  assign rnum      = cfg_wdata_i[RSEL_W-1:0];
  assign in_rng    = rnum <= LAST_RULE;
  assign cmd_wr    = cfg_we_i && (cfg_sel_i == SEL_CMD);
  assign do_commit = cmd_wr && in_rng && cfg_wdata_i[RSEL_W];
  assign do_load   = cmd_wr && in_rng && !cfg_wdata_i[RSEL_W] && cfg_wdata_i[RSEL_W+1];
  assign unused_wdata = ^cfg_wdata_i[DATA_W-1:2*PAGE_W];

  for (genvar g = 0; g < N_RULES; g++) begin : g_rule
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    rules_o[g] <= '0;
      else if (do_commit && rnum == RSEL_W'(g))       rules_o[g] <= stage_q;
    end
  end

  always_comb begin
    load_rule = '0;
    for (int i = 0; i < N_RULES; i++)
      if (rnum == RSEL_W'(i)) load_rule = rules_o[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      sel_q   <= '0;
      dflt_q  <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_CMD: begin
          sel_q <= rnum;
          if (do_load) stage_q <= load_rule;
        end
        SEL_WIN: begin
          stage_q.lo_pg <= cfg_wdata_i[PAGE_W-1:0];
          stage_q.hi_pg <= cfg_wdata_i[2*PAGE_W-1:PAGE_W];
        end
        SEL_IDR: begin
          stage_q.lo_id <= cfg_wdata_i[ID_W-1:0];
          stage_q.hi_id <= cfg_wdata_i[2*ID_W-1:ID_W];
        end
        SEL_ATTR: begin
          stage_q.sec    <= cfg_wdata_i[SEC_W-1:0];
          stage_q.valid  <= cfg_wdata_i[SEC_W];
          stage_q.pmask  <= cfg_wdata_i[SEC_W+1 +: N_PORTS];
          stage_q.result <= cfg_wdata_i[SEC_W+1+N_PORTS];
        end
        SEL_DFLT: dflt_q <= cfg_wdata_i[N_PORTS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_sel_e'(cfg_sel_i))
      SEL_CMD:  cfg_rdata_o[RSEL_W-1:0]   = sel_q;
      SEL_WIN:  cfg_rdata_o[2*PAGE_W-1:0] = {stage_q.hi_pg, stage_q.lo_pg};
      SEL_IDR:  cfg_rdata_o[2*ID_W-1:0]   = {stage_q.hi_id, stage_q.lo_id};
      SEL_ATTR: cfg_rdata_o[ATTR_W-1:0]   = {stage_q.result, stage_q.pmask,
                                              stage_q.valid, stage_q.sec};
      SEL_DFLT: cfg_rdata_o[N_PORTS-1:0]  = dflt_q;
      default: ;
    endcase
  end

  assign dflt_o = dflt_q;
endmodule

// File: rtl/prot_rule_match.sv
`timescale 1ns/1ps
module prot_rule_match
  import prot_chk_pkg::*;
(
  input  rule_t             rule_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              secure_i,
  output logic              hit_o
);
  logic [N_PORTS-1:0] port_oh;
  logic pg_ok, id_ok, port_ok, sec_ok;

  // ports beyond N_PORTS shift out to zero and never match
  assign port_oh = {{(N_PORTS-1){1'b0}}, 1'b1} << port_i;
  assign pg_ok   = (page_i >= rule_i.lo_pg) && (page_i <= rule_i.hi_pg);
  assign id_ok   = (id_i >= rule_i.lo_id) && (id_i <= rule_i.hi_id);
  assign port_ok = |(port_oh & rule_i.pmask);
  assign sec_ok  = secure_i ? rule_i.sec[1] : rule_i.sec[0];
  assign hit_o   = rule_i.valid && pg_ok && id_ok && port_ok && sec_ok;
endmodule

// File: rtl/prot_decide.sv
`timescale 1ns/1ps
module prot_decide
  import prot_chk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PORT_W-1:0]  req_port_i,
  input  logic [N_RULES-1:0] hits_i,
  input  logic [N_RULES-1:0] results_i,
  input  logic [N_PORTS-1:0] dflt_i,
  output logic               rsp_valid_o,
  output logic               rsp_accept_o,
  output logic               rsp_reject_o
);
  logic [N_PORTS-1:0] port_oh;
  logic found, rej;

  assign port_oh = {{(N_PORTS-1){1'b0}}, 1'b1} << req_port_i;

  always_comb begin
    found = 1'b0;
    rej   = 1'b0;
    // walk downward so the lowest-numbered hit is applied last
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        found = 1'b1;
        rej   = results_i[i];
      end
    end
    // an out-of-range port has no clear default bit, so it rejects
    if (!found) rej = ~|(port_oh & ~dflt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_accept_o <= 1'b0;
      rsp_reject_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_accept_o <= req_valid_i && !rej;
      rsp_reject_o <= req_valid_i && rej;
    end
  end
endmodule

// File: rtl/prot_checker.sv
`timescale 1ns/1ps
module prot_checker
  import prot_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              req_secure_i,
  output logic              rsp_valid_o,
  output logic              rsp_accept_o,
  output logic              rsp_reject_o
);
  rule_t [N_RULES-1:0] rules;
  logic  [N_PORTS-1:0] dflt;
  logic  [N_RULES-1:0] hits, results;
  logic  [PAGE_W-1:0]  page;
  logic                unused_addr;

  assign page        = req_addr_i[ADDR_W-1 -: PAGE_W];
  assign unused_addr = ^req_addr_i[ADDR_W-PAGE_W-1:0];

  prot_rule_regs u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .cfg_rdata_o,
    .rules_o (rules),
    .dflt_o  (dflt)
  );

  for (genvar g = 0; g < N_RULES; g++) begin : g_match
    assign results[g] = rules[g].result;
    prot_rule_match u_match (
      .rule_i   (rules[g]),
      .page_i   (page),
      .port_i   (req_port_i),
      .id_i     (req_id_i),
      .secure_i (req_secure_i),
      .hit_o    (hits[g])
    );
  end

  prot_decide u_decide (
    .clk_i, .rst_ni, .req_valid_i, .req_port_i,
    .hits_i    (hits),
    .results_i (results),
    .dflt_i    (dflt),
    .rsp_valid_o, .rsp_accept_o, .rsp_reject_o
  );
endmodule

// File: rtl/prot_checker_chk.sv
`timescale 1ns/1ps
module prot_checker_chk
  import prot_chk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_sel_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              req_valid_i,
  input logic [PORT_W-1:0] req_port_i,
  input logic              rsp_valid_o,
  input logic              rsp_accept_o,
  input logic              rsp_reject_o
);
  // R9
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R9
  idle_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_accept_o && !rsp_reject_o));
  // R9
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_accept_o, rsp_reject_o}) == 1));
  // R8
  bad_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_port_i >= PORT_W'(N_PORTS)) |=> rsp_reject_o);
  // R2
  cmd_bits_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_i == SEL_CMD) |-> (cfg_rdata_o[DATA_W-1:RSEL_W] == '0));
  // R11
  dflt_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_DFLT) |=>
      (cfg_sel_i != SEL_DFLT ||
       cfg_rdata_o == {{(DATA_W-N_PORTS){1'b0}}, $past(cfg_wdata_i[N_PORTS-1:0])}));
endmodule

bind prot_checker prot_checker_chk u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .cfg_rdata_o,
  .req_valid_i, .req_port_i, .rsp_valid_o, .rsp_accept_o, .rsp_reject_o
);

// File: tb/prot_checker_bench.sv
`timescale 1ns/1ps
module prot_checker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [2:0]  cfg_sel_i;
  logic [31:0] cfg_wdata_i;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic [3:0]  req_port_i;
  logic [11:0] req_id_i;
  logic        req_secure_i;
  logic        rsp_valid_o, rsp_accept_o, rsp_reject_o;

  always #2.5 clk_i = ~clk_i;

  prot_checker u_prot_checker (.*);

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state: raw register words
  int          m_sel;
  logic [31:0] m_win, m_id, m_attr, m_dflt;
  logic [31:0] r_win [20];
  logic [31:0] r_id  [20];
  logic [31:0] r_attr[20];

  function automatic logic [31:0] attr(int sec, int vld, int pmask, int res);
    return (32'(res) << 13) | ((32'(pmask) & 32'h3FF) << 3) | (32'(vld) << 2) | (32'(sec) & 3);
  endfunction

  function automatic logic [31:0] model_read(int sel);
    case (sel)
      0: return 32'(m_sel);
      1: return m_win;
      2: return m_id;
      3: return m_attr;
      4: return m_dflt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic model_reject(logic [31:0] addr, int port, int id, logic sec);
    int page = int'(addr[31:20]);
    for (int r = 0; r < 20; r++) begin
      if (r_attr[r][2] && port < 10 && r_attr[r][3+port] &&
          page >= int'(r_win[r][11:0]) && page <= int'(r_win[r][23:12]) &&
          id >= int'(r_id[r][11:0]) && id <= int'(r_id[r][23:12]) &&
          (sec ? r_attr[r][1] : r_attr[r][0]))
        return r_attr[r][13];
    end
    if (port >= 10) return 1'b1;
    return m_dflt[port];
  endfunction

  task automatic model_write(int sel, logic [31:0] w);
    int r;
    case (sel)
      0: begin
        r = int'(w[4:0]);
        m_sel = r;
        if (r < 20) begin
          if (w[5]) begin
            r_win[r] = m_win; r_id[r] = m_id; r_attr[r] = m_attr;
          end else if (w[6]) begin
            m_win = r_win[r]; m_id = r_id[r]; m_attr = r_attr[r];
          end
        end
      end
      1: m_win  = w & 32'h00FF_FFFF;
      2: m_id   = w & 32'h00FF_FFFF;
      3: m_attr = w & 32'h0000_3FFF;
      4: m_dflt = w & 32'h0000_03FF;
      default: ;
    endcase
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check readback, then check the verdict at the next negedge
  task automatic step(bit we, int sel, logic [31:0] wd, bit rv, logic [31:0] addr,
                      int port, int id, bit sec, string tag);
    logic rej;
    logic [2:0] exp_rsp;
    cfg_we_i = we; cfg_sel_i = 3'(sel); cfg_wdata_i = wd;
    req_valid_i = rv; req_addr_i = addr; req_port_i = 4'(port);
    req_id_i = 12'(id); req_secure_i = sec;
    #1;
    check(tag, "rdata", cfg_rdata_o, model_read(sel));
    rej = rv ? model_reject(addr, port, id, sec) : 1'b0;
    exp_rsp = {rv, rv & ~rej, rv & rej};
    if (we) model_write(sel, wd);
    @(negedge clk_i);
    check(tag, "rsp{v,acc,rej}", 32'({rsp_valid_o, rsp_accept_o, rsp_reject_o}), 32'(exp_rsp));
  endtask

  task automatic cfg(int sel, logic [31:0] wd, string tag);
    step(1, sel, wd, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic req(logic [31:0] addr, int port, int id, bit sec, string tag);
    step(0, 0, 0, 1, addr, port, id, sec, tag);
  endtask

  task automatic rd(int sel, string tag);
    step(0, sel, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic prog(int n, logic [31:0] win, logic [31:0] idw, logic [31:0] at, string tag);
    cfg(1, win, tag);
    cfg(2, idw, tag);
    cfg(3, at, tag);
    cfg(0, 32'h20 | 32'(n), tag);
  endtask

  initial begin
    m_sel = 0; m_win = 0; m_id = 0; m_attr = 0; m_dflt = 0;
    for (int r = 0; r < 20; r++) begin r_win[r] = 0; r_id[r] = 0; r_attr[r] = 0; end
    rst_ni = 1'b0; cfg_we_i = 0; cfg_sel_i = 0; cfg_wdata_i = 0;
    req_valid_i = 1; req_addr_i = 0; req_port_i = 0; req_id_i = 0; req_secure_i = 0;
    repeat (3) @(negedge clk_i);
    // R1 outputs idle while in reset
    check("R1", "rsp in reset", 32'({rsp_valid_o, rsp_accept_o, rsp_reject_o}), 32'h0);
    rst_ni = 1'b1;

    // R1 every register zero, all traffic accepted
    for (int s = 0; s < 8; s++) step(0, s, 0, 1, 32'(s) << 28, s, s * 300, s[0], "R1");

    // R4 R5 rule 3: pages 0x010..0x01F, any id, all ports, both security, reject
    prog(3, 32'h01F_010, 32'hFFF_000, attr(3, 1, 10'h3FF, 1), "R4");
    rd(1, "R4"); rd(2, "R4"); rd(3, "R4"); rd(0, "R2");
    req(32'h00FF_FFFF, 0, 0, 0, "R5");
    req(32'h0100_0000, 0, 0, 0, "R5");
    req(32'h01FF_FFFF, 9, 4095, 1, "R5");
    req(32'h0200_0000, 0, 0, 0, "R5");

    // R6 rule 1 inside rule 3: page 0x018, ids 5..7, port 2, secure only, accept
    prog(1, 32'h018_018, 32'h007_005, attr(2, 1, 10'h004, 0), "R6");
    req(32'h0180_0000, 2, 6, 1, "R6");
    req(32'h018F_FFFF, 2, 5, 1, "R6");
    req(32'h0180_0000, 2, 7, 1, "R6");
    req(32'h0180_0000, 2, 6, 0, "R5");
    req(32'h0180_0000, 2, 8, 1, "R5");
    req(32'h0180_0000, 2, 4, 1, "R5");
    req(32'h0180_0000, 3, 6, 1, "R5");
    req(32'h0170_0000, 2, 6, 1, "R5");

    // R10 commit to rule 0 and request in the same cycle
    cfg(1, 32'h010_010, "R10");
    step(1, 0, 32'h20 | 32'd0, 1, 32'h0100_0000, 2, 6, 1, "R10");
    req(32'h0100_0000, 2, 6, 1, "R10");

    // R7 default mask
    cfg(4, 32'hFFFF_FFFF, "R7");
    rd(4, "R11");
    req(32'h0500_0000, 0, 0, 0, "R7");
    cfg(4, 32'h004, "R7");
    req(32'h0500_0000, 2, 0, 0, "R7");
    req(32'h0500_0000, 1, 0, 0, "R7");

    // R8 out-of-range ports reject, even inside an all-port rule with a clear default
    cfg(4, 32'h0, "R8");
    req(32'h0150_0000, 12, 0, 0, "R8");
    req(32'h0500_0000, 15, 0, 1, "R8");
    req(32'h0500_0000, 10, 0, 1, "R8");

    // R3 load rule 3 back into cleared staging
    cfg(1, 0, "R3"); cfg(2, 0, "R3"); cfg(3, 0, "R3");
    cfg(0, 32'h40 | 32'd3, "R3");
    rd(1, "R3"); rd(2, "R3"); rd(3, "R3"); rd(0, "R2");
    // R3 both bits: commit rule 3 copy into rule 1, no load
    cfg(1, 32'h030_030, "R3");
    cfg(0, 32'h60 | 32'd1, "R3");
    rd(1, "R3");
    req(32'h0300_0000, 4, 100, 0, "R3");
    req(32'h0180_0000, 2, 6, 1, "R3");
    // R3 out-of-range rule numbers ignored
    cfg(0, 32'h20 | 32'd25, "R3");
    cfg(0, 32'h40 | 32'd22, "R3");
    rd(0, "R3"); rd(1, "R3");
    req(32'h0100_0000, 2, 6, 1, "R3");

    // R11 unused selects
    cfg(5, 32'hFFFF_FFFF, "R11"); cfg(6, 32'h1234_5678, "R11"); cfg(7, 32'hFFFF_FFFF, "R11");
    rd(5, "R11"); rd(6, "R11"); rd(7, "R11"); rd(4, "R11"); rd(1, "R11");

    // R4 clearing valid on rule 3 stops its match
    cfg(1, 32'h01F_010, "R4"); cfg(2, 32'hFFF_000, "R4");
    cfg(3, attr(3, 0, 10'h3FF, 1), "R4");
    cfg(0, 32'h20 | 32'd3, "R4");
    req(32'h0150_0000, 0, 0, 0, "R4");
    // R1 clear the whole table with zeroed staging
    cfg(1, 0, "R1"); cfg(2, 0, "R1"); cfg(3, 0, "R1");
    for (int r = 0; r < 20; r++) cfg(0, 32'h20 | 32'(r), "R1");
    req(32'h0100_0000, 2, 6, 1, "R1");
    req(32'h0000_0000, 0, 0, 0, "R1");

    // mixed traffic R5 R6 R7 R9
    for (int k = 0; k < 600; k++) begin
      int unsigned x = $urandom;
      int sel = int'(x % 5);
      logic [31:0] w;
      case (sel)
        0: w = ($urandom % 4 == 0) ? 32'h40 | ($urandom % 22) : 32'h20 | ($urandom % 22);
        1: begin int lo = $urandom % 16; w = 32'(((lo + $urandom % 8) << 12) | lo); end
        2: begin int lo = $urandom % 8;  w = 32'(((lo + $urandom % 8) << 12) | lo); end
        default: w = $urandom;
      endcase
      step(x[8] && x[9], sel, w, x[10], {8'(($urandom % 24)), 24'($urandom)},
           int'($urandom % 12), int'($urandom % 16), x[11], "R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule